// File: doc/BRIEF.md
# Adjustable Onboard Time Counter

This block keeps vehicle time as a whole-second count and a microsecond count, both advanced from a fixed reference clock that is divided down to one microsecond tick. Software steers the time through a small register bus: it can jump the time to a new value in one step, hand the block a signed number of microseconds to absorb gradually, and set a signed rate word that trims away steady drift of the reference oscillator.

The gradual correction never jumps. Each correction adds one extra microsecond tick or drops one tick. Corrections happen only at evenly spaced slots, so a one-second interval sees no more than 100 µs of change. The rate trim is an accumulator that adds the rate word on every tick and inserts or removes one tick each time it crosses its range. Both kinds of correction may land on the same tick, and both are then applied. The block drives the live time and a one-cycle pulse at every second boundary. Reading the microsecond register freezes the seconds value for a later read, so a two-word read is always coherent.

Top module: `ob_time_keeper`

## Requirements
- R1: With no correction pending, each microsecond tick (one per `CPT` reference clocks) adds exactly 1 to the microsecond count. That count runs 0 to `TPS`-1, and on wrapping to 0 it adds 1 to the seconds count.
- R2: Under reset the time reads 0.0, `pps` is low, and the slew residual (address 2) and the rate word (address 3) read 0.
- R3: A write to address 1 stages a seconds value. A write to address 0 with a value below `TPS` loads the staged seconds and that microsecond value. The loaded values appear on the time outputs in the next cycle exactly, and the load overrides any correction due in the same cycle.
- R4: A write to address 0 with a value of `TPS` or more leaves the time unchanged and raises no `pps`.
- R5: `pps` is high for one cycle after each microsecond wrap, and in the cycle after each coarse load. While `pps` is high following a wrap, the microsecond count reads 0.
- R6: The slew residual at address 2 is a signed 32-bit count of microseconds. At each slot, one every `TPS`/`MAX_SLEW` ticks, a nonzero residual causes one extra tick if it is positive and one dropped tick if it is negative. The residual then moves one step toward zero and stays at zero once it gets there.
- R7: At most `MAX_SLEW` slew corrections take place in any `TPS` consecutive ticks. A large residual therefore shifts time by exactly one microsecond per slot.
- R8: The rate word at address 3 is a signed `ACC_W`-bit value, sign-extended when read. Every tick it is added to an unsigned `ACC_W`-bit accumulator. A sum at or above 2^`ACC_W` inserts one tick, and a sum below zero drops one. A rate of ±2^20 with `ACC_W`=24 therefore corrects once every 16 ticks.
- R9: A slew correction and a trim correction that fall on the same tick are both applied, for a net step of −1 to +3 microseconds.
- R10: A read of address 0 returns the microsecond count and latches the seconds count. A read of address 1 returns the latched seconds, even after the live seconds have moved on.
- R11: The slew residual and the rate word read back the value last written, the residual less any slots it has since consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 2 | Register address: 0 microseconds, 1 seconds, 2 slew residual, 3 rate word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| time_sec | output | 32 | Live seconds count |
| time_sub | output | 20 | Live microsecond count |
| pps | output | 1 | One-cycle second-boundary pulse |

## Verification
Two pairs of functions can fall in the same cycle. A slew slot can coincide with a trim overflow, and a coarse load can coincide with either correction. The first case is provoked by running a large same-signed residual together with a rate of ±2^20 across 800 ticks. Slots come every 10 ticks and overflows every 16, so they coincide every 80 ticks. The elapsed time between two coherent snapshots must then equal the tick count plus or minus both correction totals exactly. For the second case, a coarse load is issued while both engines are active, and the outputs in the following cycle must show the loaded value unaltered.

// File: rtl/otc_pkg.sv
package otc_pkg;

    localparam int SEC_W  = 32;
    localparam int SUB_W  = 20;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'b00,
        ADJ_ADD  = 2'b01,
        ADJ_DROP = 2'b11
    } adj_e;

    typedef enum logic [1:0] {
        RA_SUB  = 2'd0,
        RA_SEC  = 2'd1,
        RA_SLEW = 2'd2,
        RA_RATE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } otime_t;

    function automatic logic signed [2:0] adj_weight(adj_e a);
        case (a)
            ADJ_ADD:  return 3'sd1;
            ADJ_DROP: return -3'sd1;
            default:  return 3'sd0;
        endcase
    endfunction

    // microseconds advanced on one tick: base tick plus both corrections
    function automatic logic signed [2:0] tick_delta(adj_e a, adj_e b);
        return 3'sd1 + adj_weight(a) + adj_weight(b);
    endfunction

endpackage

// File: rtl/otc_tick_gen.sv
module otc_tick_gen #(
    parameter int CPT = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CPT > 1) ? $clog2(CPT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CPT - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R1
endmodule

// File: rtl/otc_slew.sv
module otc_slew import otc_pkg::*; #(
    parameter int GAP   = 10000,
    parameter int RES_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    wr,
    input  logic signed [RES_W-1:0] wr_val,
    output logic signed [RES_W-1:0] residual,
    output adj_e                    adj
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [GW-1:0] G_LAST = GW'(GAP - 1);
    localparam logic signed [RES_W-1:0] ONE = 1;

    logic [GW-1:0] gcnt;
    logic          slot;
    logic          fire;

    assign slot = tick && (gcnt == G_LAST);
    assign fire = slot && (residual != '0);

    always_comb begin
        if (!fire)                  adj = ADJ_NONE;
        else if (residual[RES_W-1]) adj = ADJ_DROP;
        else                        adj = ADJ_ADD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gcnt     <= '0;
            residual <= '0;
        end else begin
            if (tick) gcnt <= (gcnt == G_LAST) ? '0 : gcnt + GW'(1);
            if (wr)
                residual <= wr_val;
            else if (fire)
                residual <= residual[RES_W-1] ? residual + ONE : residual - ONE;
        end
    end

    // spacing monitor: ticks seen since the last correction
    logic [GW-1:0] since;
    always_ff @(posedge clk) begin
        if (rst)
            since <= '0;
        else if (tick)
            since <= (adj != ADJ_NONE) ? '0 : ((since == G_LAST) ? since : since + GW'(1));
    end

    AST_SLEW_SPACED: assert property (@(posedge clk) disable iff (rst)
        (adj != ADJ_NONE) |-> (since == G_LAST)); // R7
    AST_SLEW_DOWN: assert property (@(posedge clk) disable iff (rst)
        (adj == ADJ_ADD && !wr) |=> (residual == $past(residual) - ONE)); // R6
    AST_SLEW_UP: assert property (@(posedge clk) disable iff (rst)
        (adj == ADJ_DROP && !wr) |=> (residual == $past(residual) + ONE)); // R6
    AST_SLEW_REST: assert property (@(posedge clk) disable iff (rst)
        (residual == '0 && !wr) |=> (residual == '0)); // R6
endmodule

// File: rtl/otc_trim.sv
module otc_trim import otc_pkg::*; #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    wr,
    input  logic signed [ACC_W-1:0] wr_val,
    output logic signed [ACC_W-1:0] rate,
    output adj_e                    adj
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W+1:0] sum;

    // two guard bits: top bit marks a borrow, next bit marks a carry
    assign sum = {2'b00, acc} + {{2{rate[ACC_W-1]}}, rate};

    always_comb begin
        if (!tick)           adj = ADJ_NONE;
        else if (sum[ACC_W+1]) adj = ADJ_DROP;
        else if (sum[ACC_W]) adj = ADJ_ADD;
        else                 adj = ADJ_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            rate <= '0;
        end else begin
            if (wr)   rate <= wr_val;
            if (tick) acc  <= sum[ACC_W-1:0];
        end
    end

    AST_TRIM_ADD_SIGN: assert property (@(posedge clk) disable iff (rst)
        (adj == ADJ_ADD) |-> (rate > 0)); // R8
    AST_TRIM_DROP_SIGN: assert property (@(posedge clk) disable iff (rst)
        (adj == ADJ_DROP) |-> (rate < 0)); // R8
endmodule

// File: rtl/otc_counter.sv
module otc_counter import otc_pkg::*; #(
    parameter int TPS = 1000000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  adj_e   slew_adj,
    input  adj_e   trim_adj,
    input  logic   load,
    input  otime_t load_val,
    output otime_t now,
    output logic   pps
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TPS - 1);
    localparam logic [SUB_W:0]   SUB_SPAN = (SUB_W + 1)'(TPS);
    localparam logic [SEC_W-1:0] SEC_ONE  = SEC_W'(1);
    localparam logic [SUB_W-1:0] SUB_ONE  = SUB_W'(1);

    logic signed [2:0] delta;
    logic [SUB_W:0]    sum;
    otime_t            nxt;
    logic              wrap;

    always_comb begin
        delta = tick_delta(slew_adj, trim_adj);
        sum   = {1'b0, now.sub} + {{(SUB_W-1){1'b0}}, delta[1:0]};
        nxt   = now;
        wrap  = 1'b0;
        if (tick) begin
            if (delta[2]) begin
                // net step of -1: borrow from the seconds when at zero
                if (now.sub == '0) begin
                    nxt.sub = SUB_LAST;
                    nxt.sec = now.sec - SEC_ONE;
                end else begin
                    nxt.sub = now.sub - SUB_ONE;
                end
            end else if (sum >= SUB_SPAN) begin
                nxt.sub = SUB_W'(sum - SUB_SPAN);
                nxt.sec = now.sec + SEC_ONE;
                wrap    = 1'b1;
            end else begin
                nxt.sub = sum[SUB_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
            pps <= 1'b0;
        end else if (load) begin
            now <= load_val;
            pps <= 1'b1;
        end else begin
            now <= nxt;
            pps <= wrap;
        end
    end

    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
        {1'b0, now.sub} < SUB_SPAN); // R1
    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
        load |=> (now == $past(load_val))); // R3
    AST_PPS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        pps |-> $past(load || tick)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(now)); // R1
endmodule

// File: rtl/ob_time_keeper.sv
module ob_time_keeper import otc_pkg::*; #(
    parameter int TPS      = 1000000,
    parameter int CPT      = 10,
    parameter int MAX_SLEW = 100,
    parameter int ACC_W    = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SEC_W-1:0]  time_sec,
    output logic [SUB_W-1:0]  time_sub,
    output logic              pps
);
    localparam int SLEW_GAP = TPS / MAX_SLEW;

    reg_addr_e addr_e;
    logic      tick;
    logic      ld_ok;
    logic      wr_slew;
    logic      wr_rate;
    adj_e      slew_adj;
    adj_e      trim_adj;
    otime_t    now;
    otime_t    load_val;

    logic [SEC_W-1:0]         sec_stage;
    logic [SEC_W-1:0]         sec_snap;
    logic signed [DATA_W-1:0] residual;
    logic signed [ACC_W-1:0]  rate;

    assign addr_e  = reg_addr_e'(bus_addr);
    assign ld_ok   = bus_wr && (addr_e == RA_SUB) && (bus_wdata < DATA_W'(TPS));
    assign wr_slew = bus_wr && (addr_e == RA_SLEW);
    assign wr_rate = bus_wr && (addr_e == RA_RATE);
    assign load_val.sec = sec_stage;
    assign load_val.sub = bus_wdata[SUB_W-1:0];

    otc_tick_gen #(.CPT(CPT)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    otc_slew #(.GAP(SLEW_GAP), .RES_W(DATA_W)) u_slew (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr       (wr_slew),
        .wr_val   (bus_wdata),
        .residual (residual),
        .adj      (slew_adj)
    );

    otc_trim #(.ACC_W(ACC_W)) u_trim (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .wr     (wr_rate),
        .wr_val (bus_wdata[ACC_W-1:0]),
        .rate   (rate),
        .adj    (trim_adj)
    );

    otc_counter #(.TPS(TPS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .slew_adj (slew_adj),
        .trim_adj (trim_adj),
        .load     (ld_ok),
        .load_val (load_val),
        .now      (now),
        .pps      (pps)
    );

    assign time_sec = now.sec;
    assign time_sub = now.sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_stage <= '0;
            sec_snap  <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr && addr_e == RA_SEC) sec_stage <= bus_wdata;
            if (bus_rd) begin
                case (addr_e)
                    RA_SUB: begin
                        bus_rdata <= {{(DATA_W-SUB_W){1'b0}}, now.sub};
                        sec_snap  <= now.sec;
                    end
                    RA_SEC:  bus_rdata <= sec_snap;
                    RA_SLEW: bus_rdata <= residual;
                    default: bus_rdata <= {{(DATA_W-ACC_W){rate[ACC_W-1]}}, rate};
                endcase
            end
        end
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && addr_e == RA_SUB) |=> $stable(sec_snap)); // R10
    AST_BAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && addr_e == RA_SUB && !ld_ok && !tick) |=> ($stable(now) && !pps)); // R4
endmodule

// File: tb/sim_ob_time_keeper.sv
module sim_ob_time_keeper;
    localparam int TPS = 1000;
    localparam int CPT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [31:0] time_sec;
    logic [19:0] time_sub;
    logic        pps;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ob_time_keeper #(.TPS(TPS), .CPT(CPT), .MAX_SLEW(100), .ACC_W(24)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .time_sec(time_sec), .time_sub(time_sub), .pps(pps)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every bus task starts and ends at a falling edge, one cycle each
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap(output longint t);
        logic [31:0] s, h;
        rd(2'd0, s);
        rd(2'd1, h);
        t = longint'(h) * TPS + longint'(s);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        idle(3);
        check("R2 sec in reset", time_sec, 0);
        check("R2 sub in reset", time_sub, 0);
        check("R2 pps in reset", pps, 0);
        rst = 1'b0;
        @(negedge clk);
        rd(2'd2, r); check("R2 residual", r, 0);
        rd(2'd3, r); check("R2 rate", r, 0);
    endtask

    task automatic t_freerun();
        longint a, b;
        snap(a); idle(2*200 - 2); snap(b);
        check("R1 free run 200 ticks", b - a, 200);
    endtask

    task automatic t_load();
        wr(2'd1, 32'd42);
        wr(2'd0, 32'd123);
        check("R3 loaded sec", time_sec, 42);
        check("R3 loaded sub", time_sub, 123);
        check("R5 pps on load", pps, 1);
        idle(1);
        check("R5 pps single cycle", pps, 0);
    endtask

    task automatic t_bad_load();
        logic [31:0] s0;
        s0 = time_sec;
        wr(2'd1, 32'd99);
        wr(2'd0, TPS);
        check("R4 sec kept", time_sec, s0);
        check("R4 no pps", pps, 0);
    endtask

    task automatic t_wrap();
        int cnt = 0;
        bit prev = 1'b0;
        wr(2'd1, 32'd7);
        wr(2'd0, 32'd990);
        idle(1);
        for (int i = 0; i < 40; i++) begin
            if (pps) begin
                cnt++;
                check("R5 sec at wrap pulse", time_sec, 8);
                check("R5 sub at wrap pulse", time_sub, 0);
                check("R5 pulse not repeated", prev, 0);
            end
            prev = pps;
            idle(1);
        end
        check("R5 one wrap pulse", cnt, 1);
        check("R1 seconds carried", time_sec, 8);
    endtask

    task automatic t_coherent();
        logic [31:0] s, h;
        wr(2'd1, 32'd3);
        wr(2'd0, 32'd900);
        rd(2'd0, s);
        check("R10 sub at latch", (s >= 900 && s <= 901) ? 1 : 0, 1);
        idle(400);
        check("R1 live sec moved", time_sec, 4);
        rd(2'd1, h);
        check("R10 latched sec kept", h, 3);
    endtask

    task automatic t_slew_small(input int amount);
        longint a, b;
        logic [31:0] r;
        snap(a);
        wr(2'd2, amount);
        idle(2*400 - 2 - 1);
        snap(b);
        check("R6 slew absorbed", b - a, 400 + amount);
        rd(2'd2, r);
        check("R6 residual reaches zero", r, 0);
    endtask

    task automatic t_slew_limit(input int amount, input int expect_shift);
        longint a, b;
        wr(2'd2, amount);
        snap(a); idle(2*500 - 2); snap(b);
        check("R7 slew rate limited", b - a, 500 + expect_shift);
        wr(2'd2, 0);
    endtask

    task automatic t_trim(input int rate_v, input int expect_shift);
        longint a, b;
        wr(2'd3, rate_v);
        snap(a); idle(2*1600 - 2); snap(b);
        check("R8 trim periodic", b - a, 1600 + expect_shift);
        wr(2'd3, 0);
    endtask

    task automatic t_combined(input int slew_v, input int rate_v, input int expect_shift);
        longint a, b;
        wr(2'd2, slew_v);
        wr(2'd3, rate_v);
        snap(a); idle(2*800 - 2); snap(b);
        check("R9 slew and trim together", b - a, 800 + expect_shift);
    endtask

    task automatic t_load_collide();
        wr(2'd2, 2000);
        wr(2'd3, 1 << 20);
        idle(7);
        wr(2'd1, 32'd77);
        wr(2'd0, 32'd500);
        check("R3 R9 load beats corrections sec", time_sec, 77);
        check("R3 R9 load beats corrections sub", time_sub, 500);
        wr(2'd2, 0);
        wr(2'd3, 0);
    endtask

    task automatic t_readback();
        logic [31:0] r;
        wr(2'd3, 32'hFFFF_FFB3);
        rd(2'd3, r);
        check("R11 rate readback", r, 32'hFFFF_FFB3);
        wr(2'd2, -1234);
        rd(2'd2, r);
        check("R11 residual readback",
              ($signed(r) == -1234 || $signed(r) == -1233) ? 1 : 0, 1);
        wr(2'd2, 0);
        wr(2'd3, 0);
    endtask

    initial begin
        t_reset();
        t_freerun();
        t_load();
        t_bad_load();
        t_wrap();
        t_coherent();
        t_slew_small(30);
        t_slew_small(-20);
        t_slew_limit(2000, 50);
        t_slew_limit(-2000, -50);
        t_trim(1 << 20, 100);
        t_trim(-(1 << 20), -100);
        t_combined(-2000, -(1 << 20), -130);
        t_combined(2000, 1 << 20, 130);
        t_load_collide();
        t_readback();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule